// File: doc/BRIEF.md
# Dual-Phase Serial Frame Receiver

This block turns one serial receive line into parallel words. A frame is made of a first phase and, when enabled, a second phase. Each phase has its own element count and its own word length, so the width of the received elements can change part way through a frame. A typical setup has one 16-bit element followed by twelve 20-bit elements.

The block runs on a fast system clock. The bit clock, the frame sync and the serial data arrive as plain inputs that are synchronous to that clock and much slower than it. The block picks out the sampling edge of the bit clock and detects frame start on the inactive-to-active edge of frame sync. It then waits a programmable number of bit clocks before it takes the first data bit. Each finished element leaves on a valid/ready output with a tag that names its phase and its element index.

Back-pressure rules: while `valid_o` is high and `ready_i` is low, the word and its tag are held unchanged. A word is consumed on a clock edge where both `valid_o` and `ready_i` are high. There is one holding register and no queue. If another element completes while the held word has not been consumed, that element is discarded and `overrun_o` pulses for one clock.

Top module: `duo_frame_rx`

Configuration bus `cfg_i` field layout:

| Bits | Field | Meaning |
|------|-------|---------|
| 0 | two_ph | 1 means phase 2 follows phase 1 |
| 7:1 | cnt1 | phase 1 element count minus one |
| 10:8 | wl1 | phase 1 word length code |
| 17:11 | cnt2 | phase 2 element count minus one |
| 20:18 | wl2 | phase 2 word length code |
| 21 | clk_rise | 1 means sample on the rising bit clock edge |
| 22 | fs_low | 1 means frame sync is active low |
| 24:23 | ddly | bit clocks from the frame sync edge to the first data bit |

## Requirements
- R1: While `rst_n` is low at a clock edge, `valid_o` and `overrun_o` are low after that edge.
- R2: With clk_rise=0, data and frame sync are sampled where the bit clock falls. With clk_rise=1, they are sampled where it rises. Values present at the other bit clock edge are never used.
- R3: A frame starts only at a sample where frame sync is active and was inactive at the previous sample. Active means high when fs_low=0 and low when fs_low=1. Frame sync held active does not start another frame.
- R4: With ddly=0, the bit sampled together with the frame sync edge is the first data bit. With ddly=1 or 2, the first data bit is the one sampled 1 or 2 samples later.
- R5: A frame is cnt1+1 elements of phase 1, then cnt2+1 elements of phase 2 when two_ph=1. After that the block idles until the next frame start.
- R6: Word length codes are 000=8, 001=12, 010=16, 011=20, 100=24, and 101, 110, 111=32 bits. Bits arrive MSB first. `word_o` is right-justified with the upper bits zero.
- R7: `tag_o[7]` is the phase (0 = first, 1 = second) and `tag_o[6:0]` is the element index within that phase, counted from 0.
- R8: While `valid_o` is high and `ready_i` is low, `valid_o`, `word_o` and `tag_o` stay unchanged.
- R9: An element that completes while a word is held and not being consumed is dropped, and `overrun_o` is high for the following clock.
- R10: For ddly of 1 or 2, a frame sync edge that arrives during the last ddly bits of a frame is honoured. The next frame's first bit then directly follows the previous last bit.
- R11: A frame start during a frame abandons the element being assembled and restarts at phase 1, element 0. Elements already delivered are not affected.
- R12: Frame sync staying active over the first data bits does not disturb the received data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | system clock |
| rst_n | input | 1 | synchronous reset, active low |
| cfg_i | input | 25 | frame configuration, layout above |
| bclk_i | input | 1 | bit clock, oversampled by clk |
| fsync_i | input | 1 | receive frame sync |
| sdata_i | input | 1 | serial receive data |
| word_o | output | 32 | received element, right-justified |
| tag_o | output | 8 | phase bit and element index |
| valid_o | output | 1 | word and tag are valid |
| ready_i | input | 1 | consumer accepts the word |
| overrun_o | output | 1 | one-clock pulse: an element was dropped |

## Verification
The bench changes the data line to its complement at the non-sampling bit clock edge. A receiver that used the wrong edge would therefore return inverted words. It places frame sync edges inside the last bits of a frame, so a receiver that only re-armed once idle would lose the gapless second frame. It holds frame sync active across a whole frame and beyond, which catches level-triggered starts as extra words. It also raises a new edge in the middle of an element, which exposes a receiver that kept the stale partial word. With the consumer stalled, it checks that the held word survives and that the second element is dropped with a single overrun pulse, not overwritten into the output.

// File: rtl/duo_frame_rx_pkg.sv
package duo_frame_rx_pkg;
  localparam int DATA_W = 32;
  localparam int CNT_W  = 7;
  localparam int WLC_W  = 3;
  localparam int DLY_W  = 2;
  localparam int BC_W   = $clog2(DATA_W) + 1;
  localparam int TAG_W  = CNT_W + 1;

  typedef struct packed {
    logic [DLY_W-1:0] ddly;
    logic             fs_low;
    logic             clk_rise;
    logic [WLC_W-1:0] wl2;
    logic [CNT_W-1:0] cnt2;
    logic [WLC_W-1:0] wl1;
    logic [CNT_W-1:0] cnt1;
    logic             two_ph;
  } cfg_t;

  localparam int CFG_W = $bits(cfg_t);

  function automatic logic [BC_W-1:0] wl_bits(input logic [WLC_W-1:0] code);
    case (code)
      3'd0:    return BC_W'(8);
      3'd1:    return BC_W'(12);
      3'd2:    return BC_W'(16);
      3'd3:    return BC_W'(20);
      3'd4:    return BC_W'(24);
      default: return BC_W'(32);
    endcase
  endfunction
endpackage

// File: rtl/duo_frame_rx_edge.sv
// Finds the sampling transition of the oversampled bit clock.
module duo_frame_rx_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic bclk,
  input  logic rise_sel,
  output logic stb
);
  logic bclk_q;

  always_ff @(posedge clk) begin
    if (!rst_n) bclk_q <= bclk;
    else        bclk_q <= bclk;
  end

  always_comb begin
    if (rise_sel) stb = !bclk_q && bclk;
    else          stb = bclk_q && !bclk;
  end
endmodule

// File: rtl/duo_frame_rx_sync.sv
// Frame start detection and data delay countdown. The countdown runs
// independently of word assembly, so a start may be armed during the tail
// of the previous frame.
module duo_frame_rx_sync
  import duo_frame_rx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stb,
  input  logic             fs_pin,
  input  logic             fs_low,
  input  logic [DLY_W-1:0] ddly,
  output logic             first
);
  logic             fs_prev_q;
  logic             arm_q;
  logic [DLY_W-1:0] left_q;
  logic             fs_act;
  logic             fs_edge;

  assign fs_act  = fs_pin ^ fs_low;
  assign fs_edge = stb && fs_act && !fs_prev_q;
  assign first   = stb && ((fs_edge && (ddly == '0)) || (!fs_edge && arm_q && (left_q == '0)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fs_prev_q <= 1'b0;
      arm_q     <= 1'b0;
      left_q    <= '0;
    end else if (stb) begin
      fs_prev_q <= fs_act;
      if (fs_edge) begin
        arm_q  <= (ddly != '0);
        left_q <= ddly - DLY_W'(1);
      end else if (arm_q) begin
        if (left_q == '0) arm_q <= 1'b0;
        else              left_q <= left_q - DLY_W'(1);
      end
    end
  end
endmodule

// File: rtl/duo_frame_rx_asm.sv
// Shifts bits into elements and steps through phases and elements.
module duo_frame_rx_asm
  import duo_frame_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              two_ph,
  input  logic [CNT_W-1:0]  cnt1,
  input  logic [WLC_W-1:0]  wl1,
  input  logic [CNT_W-1:0]  cnt2,
  input  logic [WLC_W-1:0]  wl2,
  input  logic              stb,
  input  logic              sbit,
  input  logic              first,
  output logic              cmp,
  output logic [DATA_W-1:0] cmp_data,
  output logic [TAG_W-1:0]  cmp_tag
);
  logic              busy_q, ph_q;
  logic [CNT_W-1:0]  el_q;
  logic [BC_W-1:0]   bc_q;
  logic [DATA_W-1:0] sh_q;

  logic              act, cur_ph, last_bit, last_el;
  logic [CNT_W-1:0]  cur_el, cur_cnt;
  logic [BC_W-1:0]   cur_bc, cur_wl;
  logic [DATA_W-1:0] cur_sh, nxt_sh;

  always_comb begin
    act      = stb && (first || busy_q);
    cur_ph   = first ? 1'b0 : ph_q;
    cur_el   = first ? '0 : el_q;
    cur_bc   = first ? '0 : bc_q;
    cur_sh   = first ? '0 : sh_q;
    cur_wl   = wl_bits(cur_ph ? wl2 : wl1);
    cur_cnt  = cur_ph ? cnt2 : cnt1;
    nxt_sh   = {cur_sh[DATA_W-2:0], sbit};
    last_bit = (cur_bc == cur_wl - BC_W'(1));
    last_el  = (cur_el == cur_cnt);
    cmp      = act && last_bit;
    cmp_data = nxt_sh;
    cmp_tag  = {cur_ph, cur_el};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      ph_q   <= 1'b0;
      el_q   <= '0;
      bc_q   <= '0;
      sh_q   <= '0;
    end else if (act) begin
      if (last_bit) begin
        sh_q <= '0;
        bc_q <= '0;
        if (last_el) begin
          el_q <= '0;
          if (!cur_ph && two_ph) begin
            ph_q   <= 1'b1;
            busy_q <= 1'b1;
          end else begin
            ph_q   <= 1'b0;
            busy_q <= 1'b0;
          end
        end else begin
          el_q   <= cur_el + CNT_W'(1);
          ph_q   <= cur_ph;
          busy_q <= 1'b1;
        end
      end else begin
        sh_q   <= nxt_sh;
        bc_q   <= cur_bc + BC_W'(1);
        el_q   <= cur_el;
        ph_q   <= cur_ph;
        busy_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/duo_frame_rx_out.sv
// Single holding register on a valid/ready output; drops on overrun.
module duo_frame_rx_out #(
  parameter int DW = 32,
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmp,
  input  logic [DW-1:0] cmp_data,
  input  logic [TW-1:0] cmp_tag,
  input  logic          ready,
  output logic          valid,
  output logic [DW-1:0] data,
  output logic [TW-1:0] tag,
  output logic          ovr
);
  logic take;
  assign take = cmp && (!valid || ready);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
      data  <= '0;
      tag   <= '0;
      ovr   <= 1'b0;
    end else begin
      ovr <= cmp && valid && !ready;
      if (take) begin
        valid <= 1'b1;
        data  <= cmp_data;
        tag   <= cmp_tag;
      end else if (ready) begin
        valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/duo_frame_rx.sv
module duo_frame_rx
  import duo_frame_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CFG_W-1:0]  cfg_i,
  input  logic              bclk_i,
  input  logic              fsync_i,
  input  logic              sdata_i,
  output logic [DATA_W-1:0] word_o,
  output logic [TAG_W-1:0]  tag_o,
  output logic              valid_o,
  input  logic              ready_i,
  output logic              overrun_o
);
  cfg_t              cfg;
  logic              stb, first, cmp;
  logic [DATA_W-1:0] cmp_data;
  logic [TAG_W-1:0]  cmp_tag;

  assign cfg = cfg_t'(cfg_i);

  duo_frame_rx_edge edge_i (
    .clk(clk), .rst_n(rst_n), .bclk(bclk_i), .rise_sel(cfg.clk_rise), .stb(stb)
  );

  duo_frame_rx_sync sync_i (
    .clk(clk), .rst_n(rst_n), .stb(stb), .fs_pin(fsync_i),
    .fs_low(cfg.fs_low), .ddly(cfg.ddly), .first(first)
  );

  duo_frame_rx_asm asm_i (
    .clk(clk), .rst_n(rst_n), .two_ph(cfg.two_ph),
    .cnt1(cfg.cnt1), .wl1(cfg.wl1), .cnt2(cfg.cnt2), .wl2(cfg.wl2),
    .stb(stb), .sbit(sdata_i), .first(first),
    .cmp(cmp), .cmp_data(cmp_data), .cmp_tag(cmp_tag)
  );

  duo_frame_rx_out #(.DW(DATA_W), .TW(TAG_W)) out_i (
    .clk(clk), .rst_n(rst_n), .cmp(cmp), .cmp_data(cmp_data), .cmp_tag(cmp_tag),
    .ready(ready_i), .valid(valid_o), .data(word_o), .tag(tag_o), .ovr(overrun_o)
  );
endmodule

// File: rtl/duo_frame_rx_chk.sv
module duo_frame_rx_chk
  import duo_frame_rx_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              two_ph,
  input logic [CNT_W-1:0]  cnt1,
  input logic [WLC_W-1:0]  wl1,
  input logic [CNT_W-1:0]  cnt2,
  input logic [WLC_W-1:0]  wl2,
  input logic [DATA_W-1:0] word_o,
  input logic [TAG_W-1:0]  tag_o,
  input logic              valid_o,
  input logic              ready_i,
  input logic              overrun_o
);
  logic [BC_W-1:0] held_wl;
  assign held_wl = wl_bits(tag_o[TAG_W-1] ? wl2 : wl1);

  // R1
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> (!valid_o && !overrun_o));

  // R8
  a_r8_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !ready_i) |=> (valid_o && $stable(word_o) && $stable(tag_o)));

  // R9
  a_r9_overrun_only_full: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_o |-> $past(valid_o && !ready_i));

  // R6
  a_r6_zero_fill: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> ((held_wl == BC_W'(DATA_W)) || ((word_o >> held_wl) == '0)));

  // R5, R7
  a_r5_tag_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> (tag_o[TAG_W-1] ? (two_ph && (tag_o[CNT_W-1:0] <= cnt2))
                                : (tag_o[CNT_W-1:0] <= cnt1)));
endmodule

bind duo_frame_rx duo_frame_rx_chk chk_i (
  .clk(clk), .rst_n(rst_n), .two_ph(cfg.two_ph),
  .cnt1(cfg.cnt1), .wl1(cfg.wl1), .cnt2(cfg.cnt2), .wl2(cfg.wl2),
  .word_o(word_o), .tag_o(tag_o), .valid_o(valid_o),
  .ready_i(ready_i), .overrun_o(overrun_o)
);

// File: tb/duo_frame_rx_tb_top.sv
module duo_frame_rx_tb_top;
  import duo_frame_rx_pkg::*;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [CFG_W-1:0]  cfg_i = '0;
  logic              bclk_i = 1'b0, fsync_i = 1'b0, sdata_i = 1'b0;
  logic [DATA_W-1:0] word_o;
  logic [TAG_W-1:0]  tag_o;
  logic              valid_o, overrun_o;
  logic              ready_i = 1'b1;

  always #5 clk = ~clk;

  duo_frame_rx dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_i(cfg_i), .bclk_i(bclk_i), .fsync_i(fsync_i),
    .sdata_i(sdata_i), .word_o(word_o), .tag_o(tag_o), .valid_o(valid_o),
    .ready_i(ready_i), .overrun_o(overrun_o)
  );

  int n_chk = 0, n_fail = 0, ovr_cnt = 0, wcount = 0, blen = 0;
  bit done = 1'b0;
  cfg_t cur;
  logic fs_arr [0:4095];
  logic d_arr  [0:4095];
  logic [39:0] exp_q[$];
  logic [39:0] got_q[$];

  localparam int NROW = 5;
  localparam cfg_t ROWS [NROW] = '{
    '{ddly:2'd1, fs_low:1'b0, clk_rise:1'b0, wl2:3'd3, cnt2:7'd11, wl1:3'd2, cnt1:7'd0, two_ph:1'b1},
    '{ddly:2'd0, fs_low:1'b0, clk_rise:1'b1, wl2:3'd3, cnt2:7'd5,  wl1:3'd0, cnt1:7'd3, two_ph:1'b0},
    '{ddly:2'd2, fs_low:1'b1, clk_rise:1'b0, wl2:3'd1, cnt2:7'd2,  wl1:3'd5, cnt1:7'd1, two_ph:1'b1},
    '{ddly:2'd1, fs_low:1'b0, clk_rise:1'b1, wl2:3'd7, cnt2:7'd0,  wl1:3'd4, cnt1:7'd2, two_ph:1'b1},
    '{ddly:2'd0, fs_low:1'b1, clk_rise:1'b1, wl2:3'd0, cnt2:7'd1,  wl1:3'd6, cnt1:7'd1, two_ph:1'b1}
  };
  localparam int FSLEN [NROW] = '{1, 3, 20, 5, 2};

  // Monitor, sampled between rising edges.
  always @(negedge clk) begin
    if (rst_n) begin
      if (valid_o && ready_i) got_q.push_back({tag_o, word_o});
      if (overrun_o) ovr_cnt++;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Word length decoding per R6.
  function automatic int wl_of(input logic [2:0] c);
    case (c)
      3'd0: return 8;
      3'd1: return 12;
      3'd2: return 16;
      3'd3: return 20;
      3'd4: return 24;
      default: return 32;
    endcase
  endfunction

  task automatic apply_reset(input cfg_t c);
    cur = c;
    @(negedge clk);
    rst_n = 1'b0;
    cfg_i = c;
    bclk_i = c.clk_rise;
    fsync_i = c.fs_low;
    sdata_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    got_q.delete();
    exp_q.delete();
    ovr_cnt = 0;
    blen = 0;
    for (int i = 0; i < 4096; i++) begin
      fs_arr[i] = 1'b0;
      d_arr[i] = i[0] ^ i[2];
    end
  endtask

  // One bit period: complement on the data line at the non-sampling edge,
  // the real bit and frame sync at the sampling edge (R2).
  task automatic put_bit(input logic fs, input logic d);
    @(negedge clk);
    bclk_i = ~cur.clk_rise;
    sdata_i = ~d;
    @(negedge clk);
    fsync_i = fs ^ cur.fs_low;
    sdata_i = d;
    @(negedge clk);
    bclk_i = cur.clk_rise;
    @(negedge clk);
  endtask

  task automatic add_frame(input int e, input int fs_len, input int max_words, output int endp);
    int p, n, nph, cnt, wl;
    logic [31:0] w, mask;
    p = e + int'(cur.ddly);
    n = 0;
    for (int i = e; i < e + fs_len; i++) fs_arr[i] = 1'b1;
    nph = cur.two_ph ? 2 : 1;
    for (int ph = 0; ph < nph; ph++) begin
      cnt = (ph == 1) ? int'(cur.cnt2) : int'(cur.cnt1);
      wl  = wl_of((ph == 1) ? cur.wl2 : cur.wl1);
      mask = (wl == 32) ? 32'hFFFF_FFFF : ((32'd1 << wl) - 32'd1);
      for (int el = 0; el <= cnt; el++) begin
        wcount++;
        w = (32'(wcount) * 32'h9E37_79B1 ^ 32'h5A5A_0F0F) & mask;
        for (int b = wl - 1; b >= 0; b--) begin
          d_arr[p] = w[b];
          p++;
        end
        if (n < max_words) exp_q.push_back({ph[0], el[6:0], w});
        n++;
      end
    end
    endp = p;
    if (p > blen) blen = p;
  endtask

  task automatic play();
    for (int p = 0; p < blen + 3; p++) put_bit(fs_arr[p], d_arr[p]);
    repeat (4) @(negedge clk);
  endtask

  task automatic compare_q(input string req);
    int n;
    chk(got_q.size() == exp_q.size(), {req, " word count"}, 64'(got_q.size()), 64'(exp_q.size()));
    n = (got_q.size() < exp_q.size()) ? got_q.size() : exp_q.size();
    for (int i = 0; i < n; i++)
      chk(got_q[i] === exp_q[i], {req, " tag/word"}, 64'(got_q[i]), 64'(exp_q[i]));
  endtask

  initial begin
    int endp, e2;
    cfg_t c;

    // R1: reset state.
    apply_reset(ROWS[0]);
    chk(valid_o === 1'b0, "R1 valid after reset", 64'(valid_o), 64'd0);
    chk(overrun_o === 1'b0, "R1 overrun after reset", 64'(overrun_o), 64'd0);

    // Table walk: R2, R4, R5, R6, R7, R12.
    for (int r = 0; r < NROW; r++) begin
      apply_reset(ROWS[r]);
      add_frame(2, FSLEN[r], 64, endp);
      play();
      compare_q("R2 R4 R5 R6 R7 R12 table");
    end

    // R10: gapless back-to-back frames with the edge in the previous tail.
    for (int d = 1; d <= 2; d++) begin
      c = '{ddly:2'(d), fs_low:1'b0, clk_rise:1'b0, wl2:3'd1, cnt2:7'd1, wl1:3'd0, cnt1:7'd0, two_ph:1'b1};
      apply_reset(c);
      add_frame(2, 1, 64, endp);
      add_frame(endp - d, 1, 64, e2);
      play();
      compare_q("R10 gapless");
    end

    // R3: frame sync held active over and past a frame starts only one frame.
    c = '{ddly:2'd0, fs_low:1'b0, clk_rise:1'b0, wl2:3'd0, cnt2:7'd0, wl1:3'd0, cnt1:7'd0, two_ph:1'b0};
    apply_reset(c);
    add_frame(2, 40, 64, endp);
    blen = 44;
    play();
    compare_q("R3 held sync single frame");
    add_frame(47, 1, 64, endp);
    blen = endp;
    for (int p = 44; p < blen + 3; p++) put_bit(fs_arr[p], d_arr[p]);
    repeat (4) @(negedge clk);
    compare_q("R3 new edge after release");

    // R11: new frame start in the middle of an element.
    c = '{ddly:2'd0, fs_low:1'b0, clk_rise:1'b0, wl2:3'd0, cnt2:7'd0, wl1:3'd2, cnt1:7'd1, two_ph:1'b0};
    apply_reset(c);
    add_frame(2, 1, 1, endp);
    add_frame(2 + 16 + 5, 1, 64, endp);
    play();
    compare_q("R11 mid-frame restart");

    // R8, R9: stalled consumer.
    c = '{ddly:2'd0, fs_low:1'b0, clk_rise:1'b0, wl2:3'd0, cnt2:7'd0, wl1:3'd0, cnt1:7'd1, two_ph:1'b0};
    apply_reset(c);
    @(posedge clk); #1 ready_i = 1'b0;
    add_frame(2, 1, 1, endp);
    play();
    chk(ovr_cnt == 1, "R9 overrun pulse count", 64'(ovr_cnt), 64'd1);
    chk(valid_o === 1'b1, "R8 valid held", 64'(valid_o), 64'd1);
    chk({tag_o, word_o} === exp_q[0], "R8 held word", 64'({tag_o, word_o}), 64'(exp_q[0]));
    @(posedge clk); #1 ready_i = 1'b1;
    repeat (4) @(negedge clk);
    chk(valid_o === 1'b0, "R9 drained", 64'(valid_o), 64'd0);
    compare_q("R9 dropped second word");

    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end
endmodule